// File: doc/BRIEF.md
# Timer compare output unit

This block sits beside a free-running timer and watches it against a programmable compare value. When the timer arrives at that value, the block takes the action selected by a small mode field. It can drive an output latch high, pull it low, raise only an interrupt flag, or issue a special event. The special event asks the timer to clear itself, so the compare value becomes the timer's period. In builds that enable it, the same event also requests an A/D conversion start.

Software programs the unit through a byte-wide write port. The compare value is split into byte lanes, and a separate control byte holds the mode. Writing an all-zero control byte turns off compare actions and also forces the output latch low. This latch is the block's own and is not tied to any general-purpose port register. The pin copy of the latch is driven only while the output-enable input is set. The timer, the converter and interrupt prioritisation live outside the block.

Top module: `tmr_match_out`

## Requirements
- R1: After a synchronous reset the output latch, interrupt flag, timer-clear request, conversion request and pin enable are all 0, the mode is off and the compare value is 0.
- R2: A write to address 0 loads compare bits [7:0], address 1 loads bits [15:8], and address 2 loads the control byte, whose bits [3:0] form the mode. A write to address 3 changes nothing.
- R3: In mode 4'b1000 an arrival at the compare value sets the output latch to 1 on the clock edge that sees the arrival.
- R4: In mode 4'b1001 an arrival clears the output latch to 0 on that same edge.
- R5: In mode 4'b1010 an arrival leaves the output latch unchanged and issues no timer-clear request.
- R6: In any of the four active modes, an arrival sets the interrupt flag on the edge that sees it. While irq_clr is high with no arrival, the flag returns to 0 on the next edge. An arrival wins over a clear in the same cycle.
- R7: In mode 4'b1011 an arrival produces a one-cycle tmr_clr pulse and leaves the output latch unchanged.
- R8: With ADC_TRIG=1, adc_go pulses together with tmr_clr only when adc_enabled is high in the arrival cycle. With ADC_TRIG=0, adc_go stays 0.
- R9: Any mode code other than 4'b1000 to 4'b1011 takes no action on an arrival: no flag, no timer clear, and no latch change.
- R10: An arrival is the first cycle with tmr_en high and tmr_val equal to the compare value, after a cycle with tmr_en high and the two unequal. Holding the value, or pausing with tmr_en low, does not trigger again.
- R11: A control write whose whole data byte is 0 forces the output latch to 0 on that edge. This overrides a set action from the same cycle.
- R12: pin_oe follows drv_en one edge later. pin_o equals the output latch while pin_oe is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| tmr_val | input | 16 | Current timer count |
| tmr_en | input | 1 | Timer is running and its value is valid this cycle |
| tmr_clr | output | 1 | One-cycle request to clear the timer (special event) |
| adc_enabled | input | 1 | Converter is enabled |
| adc_go | output | 1 | One-cycle conversion start request |
| irq_flag | output | 1 | Compare interrupt flag |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| out_latch | output | 1 | Compare output latch |
| drv_en | input | 1 | Pin output-enable control |
| pin_oe | output | 1 | Pin driver enable |
| pin_o | output | 1 | Pin data |

## Verification
The assertions take for granted that the timer consumes a tmr_clr pulse as a clear that is separate from an overflow. They also assume tmr_val only changes meaning while tmr_en is high, so that a stopped timer never looks like a fresh arrival. The stimulus holds every input steady from one falling edge to the next. Before each scenario it moves the timer to a value one below the compare value, so every intended arrival is a clean transition from unequal to equal. Mode changes are made only while the timer sits away from the compare value, except in the one case that deliberately pairs a zero control write with an arrival.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MD_OFF = 4'b0000;
  localparam logic [MODE_W-1:0] MD_SET = 4'b1000;
  localparam logic [MODE_W-1:0] MD_CLR = 4'b1001;
  localparam logic [MODE_W-1:0] MD_IRQ = 4'b1010;
  localparam logic [MODE_W-1:0] MD_EVT = 4'b1011;

  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:MODE_W-2] == 2'b10;
  endfunction
endpackage

// File: rtl/tmo_regs.sv
module tmo_regs
  import tmo_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [TMR_W-1:0]  cmp_val,
  output logic [MODE_W-1:0] mode,
  output logic              ctl_zero
);
  localparam int N_LANES   = TMR_W / BYTE_W;
  localparam int CTRL_ADDR = N_LANES;

  logic ctl_we;
  assign ctl_we   = we && (addr == ADDR_W'(CTRL_ADDR));
  assign ctl_zero = ctl_we && (wdata == '0);

  // one register per byte lane of the compare value
  genvar g;
  generate
    for (g = 0; g < N_LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst)
          cmp_val[g*BYTE_W +: BYTE_W] <= '0;
        else if (we && (addr == ADDR_W'(g)))
          cmp_val[g*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      mode <= MD_OFF;
    else if (ctl_we)
      mode <= wdata[MODE_W-1:0];
  end

  p_no_write_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cmp_val) && $stable(mode));
endmodule

// File: rtl/tmo_match.sv
module tmo_match #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic             tmr_en,
  input  logic [TMR_W-1:0] cmp_val,
  output logic             hit
);
  logic eq_now;
  logic eq_q;

  assign eq_now = (tmr_val == cmp_val);

  // previous equality is only updated while the timer runs, so a pause
  // at the compare value cannot look like a new arrival
  always_ff @(posedge clk) begin
    if (rst)
      eq_q <= 1'b0;
    else if (tmr_en)
      eq_q <= eq_now;
  end

  assign hit = tmr_en && eq_now && !eq_q;

  p_single_arrival_r10: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/tmo_action.sv
module tmo_action
  import tmo_pkg::*;
#(
  parameter bit ADC_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [MODE_W-1:0] mode,
  input  logic              ctl_zero,
  input  logic              irq_clr,
  input  logic              adc_en,
  input  logic              drv_en,
  output logic              out_q,
  output logic              irq_q,
  output logic              clr_q,
  output logic              adc_q,
  output logic              oe_q
);
  logic active;
  logic evt_hit;
  assign active  = mode_active(mode);
  assign evt_hit = hit && (mode == MD_EVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      irq_q <= 1'b0;
      clr_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      clr_q <= evt_hit;
      oe_q  <= drv_en;
      if (ctl_zero)
        out_q <= 1'b0;
      else if (hit && mode == MD_SET)
        out_q <= 1'b1;
      else if (hit && mode == MD_CLR)
        out_q <= 1'b0;
      if (hit && active)
        irq_q <= 1'b1;
      else if (irq_clr)
        irq_q <= 1'b0;
    end
  end

  generate
    if (ADC_TRIG) begin : g_adc
      always_ff @(posedge clk) begin
        if (rst) adc_q <= 1'b0;
        else     adc_q <= evt_hit && adc_en;
      end
      p_adc_gate_r8: assert property (@(posedge clk) disable iff (rst)
        adc_q |-> clr_q && $past(adc_en));
    end else begin : g_no_adc
      assign adc_q = 1'b0;
    end
  endgenerate

  p_evt_only_r7: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> $past(mode) == MD_EVT);
  p_flag_source_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !$past(irq_q)) |-> $past(hit));
  p_swi_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == MD_IRQ && !ctl_zero) |=> $stable(out_q));
  p_zero_low_r11: assert property (@(posedge clk) disable iff (rst)
    ctl_zero |=> !out_q);
  p_idle_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (hit && !active && !ctl_zero) |=> $stable(out_q) && !clr_q);
endmodule

// File: rtl/tmr_match_out.sv
module tmr_match_out #(
  parameter int TMR_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 2,
  parameter bit ADC_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic [TMR_W-1:0]  tmr_val,
  input  logic              tmr_en,
  output logic              tmr_clr,
  input  logic              adc_enabled,
  output logic              adc_go,
  output logic              irq_flag,
  input  logic              irq_clr,
  output logic              out_latch,
  input  logic              drv_en,
  output logic              pin_oe,
  output logic              pin_o
);
  import tmo_pkg::*;

  logic [TMR_W-1:0]  cmp_val;
  logic [MODE_W-1:0] mode;
  logic              ctl_zero;
  logic              hit;

  tmo_regs #(.TMR_W(TMR_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cmp_val(cmp_val), .mode(mode), .ctl_zero(ctl_zero)
  );

  tmo_match #(.TMR_W(TMR_W)) u_match (
    .clk(clk), .rst(rst), .tmr_val(tmr_val), .tmr_en(tmr_en),
    .cmp_val(cmp_val), .hit(hit)
  );

  tmo_action #(.ADC_TRIG(ADC_TRIG)) u_act (
    .clk(clk), .rst(rst), .hit(hit), .mode(mode), .ctl_zero(ctl_zero),
    .irq_clr(irq_clr), .adc_en(adc_enabled), .drv_en(drv_en),
    .out_q(out_latch), .irq_q(irq_flag), .clr_q(tmr_clr), .adc_q(adc_go),
    .oe_q(pin_oe)
  );

  assign pin_o = out_latch && pin_oe;

  p_clr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tmr_clr |=> !tmr_clr);
endmodule

// File: tb/tmr_match_out_test.sv
module tmr_match_out_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CV = 16'h1234;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [15:0] tmr_val = '0;
  logic tmr_en = 1'b0;
  logic adc_enabled = 1'b0;
  logic irq_clr = 1'b0;
  logic drv_en = 1'b0;
  logic tmr_clr, adc_go, irq_flag, out_latch, pin_oe, pin_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_match_out uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tmr_val(tmr_val), .tmr_en(tmr_en),
    .tmr_clr(tmr_clr), .adc_enabled(adc_enabled), .adc_go(adc_go),
    .irq_flag(irq_flag), .irq_clr(irq_clr), .out_latch(out_latch),
    .drv_en(drv_en), .pin_oe(pin_oe), .pin_o(pin_o)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic [15:0] v);
    tmr_val = v; tmr_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic arrive();
    step(CV - 16'd1);
    step(CV);
  endtask

  task automatic t_reset();
    check("R1", "latch", out_latch, 1'b0);
    check("R1", "flag", irq_flag, 1'b0);
    check("R1", "tmr_clr", tmr_clr, 1'b0);
    check("R1", "adc_go", adc_go, 1'b0);
    check("R1", "pin_oe", pin_oe, 1'b0);
    step(16'h0000);
    check("R1", "off mode no flag at 0", irq_flag, 1'b0);
  endtask

  task automatic t_set();
    wr(2'd0, CV[7:0]);
    wr(2'd1, CV[15:8]);
    wr(2'd2, 8'h08);
    step(CV - 16'd1);
    check("R3", "no set before match", out_latch, 1'b0);
    step(CV);
    check("R3", "latch set", out_latch, 1'b1);
    check("R6", "flag set", irq_flag, 1'b1);
    check("R2", "both lanes loaded", out_latch, 1'b1);
    clear_flag();
    check("R6", "flag cleared", irq_flag, 1'b0);
  endtask

  task automatic t_low();
    step(CV - 16'd1);
    wr(2'd2, 8'h09);
    step(CV);
    check("R4", "latch cleared", out_latch, 1'b0);
    check("R6", "flag on drive-low", irq_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_swi();
    step(CV - 16'd1);
    wr(2'd2, 8'h08);
    step(CV);
    clear_flag();
    step(CV - 16'd1);
    wr(2'd2, 8'h0A);
    step(CV);
    check("R5", "latch kept", out_latch, 1'b1);
    check("R5", "no timer clear", tmr_clr, 1'b0);
    check("R6", "flag on sw mode", irq_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_event();
    step(CV - 16'd1);
    wr(2'd2, 8'h0B);
    adc_enabled = 1'b1;
    step(CV);
    check("R7", "tmr_clr pulse", tmr_clr, 1'b1);
    check("R7", "latch kept", out_latch, 1'b1);
    check("R8", "adc_go with adc enabled", adc_go, 1'b1);
    step(16'h0000);
    check("R7", "tmr_clr one cycle", tmr_clr, 1'b0);
    check("R8", "adc_go one cycle", adc_go, 1'b0);
    adc_enabled = 1'b0;
    arrive();
    check("R7", "tmr_clr again", tmr_clr, 1'b1);
    check("R8", "no adc_go when disabled", adc_go, 1'b0);
    step(16'h0000);
    clear_flag();
  endtask

  task automatic t_hold();
    step(CV - 16'd1);
    wr(2'd2, 8'h0A);
    tmr_val = CV; tmr_en = 1'b0;
    @(negedge clk);
    check("R10", "paused timer no arrival", irq_flag, 1'b0);
    step(CV);
    check("R10", "arrival on resume", irq_flag, 1'b1);
    irq_clr = 1'b1;
    step(CV);
    irq_clr = 1'b0;
    step(CV);
    step(CV);
    check("R10", "hold no retrigger", irq_flag, 1'b0);
    tmr_en = 1'b0;
    @(negedge clk);
    step(CV);
    check("R10", "pause at value no retrigger", irq_flag, 1'b0);
    step(CV - 16'd1);
    irq_clr = 1'b1;
    step(CV);
    irq_clr = 1'b0;
    check("R6", "arrival beats clear", irq_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_zero();
    step(CV - 16'd1);
    wr(2'd2, 8'h08);
    step(CV);
    check("R3", "latch set again", out_latch, 1'b1);
    clear_flag();
    wr(2'd2, 8'h00);
    check("R11", "zero write forces low", out_latch, 1'b0);
    step(CV - 16'd1);
    wr(2'd2, 8'h08);
    cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'h00;
    tmr_val = CV;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11", "zero write beats set", out_latch, 1'b0);
    check("R6", "flag from same-cycle arrival", irq_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_other();
    step(CV - 16'd1);
    wr(2'd2, 8'h08);
    step(CV);
    clear_flag();
    wr(2'd3, 8'h00);
    check("R2", "address 3 ignored", out_latch, 1'b1);
    step(CV - 16'd1);
    wr(2'd2, 8'h05);
    step(CV);
    check("R9", "code 0101 no flag", irq_flag, 1'b0);
    check("R9", "code 0101 no clr", tmr_clr, 1'b0);
    step(CV - 16'd1);
    wr(2'd2, 8'h0C);
    step(CV);
    check("R9", "code 1100 no flag", irq_flag, 1'b0);
    check("R9", "code 1100 latch kept", out_latch, 1'b1);
  endtask

  task automatic t_pin();
    drv_en = 1'b0;
    @(negedge clk);
    check("R12", "oe off", pin_oe, 1'b0);
    check("R12", "pin released", pin_o, 1'b0);
    drv_en = 1'b1;
    @(negedge clk);
    check("R12", "oe on", pin_oe, 1'b1);
    check("R12", "pin follows latch", pin_o, 1'b1);
    wr(2'd2, 8'h00);
    check("R12", "pin follows low latch", pin_o, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set();
    t_low();
    t_swi();
    t_event();
    t_hold();
    t_zero();
    t_other();
    t_pin();
    finish_run();
  end
endmodule